// File: doc/BRIEF.md
# 8-bit ISA-style bus target

This block lets a small peripheral sit on an 8-bit parallel expansion bus of the ISA kind, driven by a host processor and a DMA controller. It captures the 20-bit address while the address-latch strobe is high and holds it for the rest of the cycle. It then answers port cycles aimed at a bank of four byte registers at a base address set by a parameter. It also answers memory cycles that fall inside a small on-chip memory window. All bus strobes are active low. They are brought into the internal clock domain through two-flop synchronisers before any decision is made.

The peripheral can ask for a DMA transfer by raising a request line. Once the controller acknowledges, each acknowledged I/O read hands out the data register with no address decode. The data register then steps by one. A terminal-count pulse during an acknowledged transfer ends the request and raises a done flag. While the controller signals that it owns the bus, port strobes are ignored. The data bus is modelled as separate input, output and output-enable signals.

Top module: `isa_bus_target`

## Requirements
- R1: After synchronous reset, dat_oe is 0, dat_out is 0x00 and dma_req is 0. The data, aux and status registers read 0x00.
- R2: The address is captured from bus_addr while the synchronised bus_ale is high. It is held unchanged while bus_ale is low, so a cycle decodes correctly after bus_addr has moved on to another value.
- R3: Four byte registers start at PORT_BASE (0x00300). Offset 0 is data (read/write). Offset 1 is aux (read/write). Offset 2 is command, which is write-only and reads 0x00. In the command byte, bit 0 = 1 raises the request and clears done, and bit 1 = 1 clears done. Offset 3 is status, read-only: bit 0 is the request and bit 1 is done; writes to it have no effect. Port addresses outside the four registers get no response.
- R4: While bus_aen is high and dma_ack_n is high, port reads never assert dat_oe and port writes change no register.
- R5: A read strobe first sampled low at rising edge k makes dat_oe and dat_out valid after edge k+2. Release of the strobe is seen with the same delay. Whenever dat_oe is 0, dat_out is 0x00.
- R6: A write is committed two clock edges after the rising edge of its strobe is first sampled, using dat_in at that edge. dat_oe is never asserted while a write strobe is low.
- R7: Memory cycles are answered only inside the 16-byte window at MEM_BASE (0xD0000), whatever the state of bus_aen. A memory write outside the window changes nothing.
- R8: While dma_ack_n is low, an I/O read drives the data register with no address decode. When that read completes, the data register increments by 1.
- R9: dma_tc high while dma_ack_n is low clears dma_req and sets done. A later start command clears done again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Bus address |
| bus_ale | input | 1 | Address-latch strobe, active high |
| bus_aen | input | 1 | High while the DMA controller owns the bus |
| io_rd_n | input | 1 | Port read strobe, active low |
| io_wr_n | input | 1 | Port write strobe, active low |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| dat_in | input | 8 | Data from the bus |
| dat_out | output | 8 | Data driven to the bus |
| dat_oe | output | 1 | Output enable for dat_out |
| dma_req | output | 1 | DMA request |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| dma_tc | input | 1 | Terminal-count pulse from the DMA controller |

## Verification
Most internal state here can only be seen on the bus when a read strobe is active. A bad register value or a mis-held address therefore shows up on dat_out during the next read of that location, two edges after the strobe is sampled low. A wrong request or done flag shows at once on dma_req, or in the status byte on the next status read. The reference model predicts dat_oe, dat_out and dma_req on every clock. A wrong synchroniser delay or a missing write suppression is therefore caught on the very cycle it first differs, and directed readback covers the state that cannot be seen directly.

// File: rtl/isa_tgt_pkg.sv
package isa_tgt_pkg;

  // number of decoded port registers
  localparam int unsigned PORT_REGS = 4;

  typedef enum logic [1:0] {
    RIX_DATA = 2'd0,
    RIX_AUX  = 2'd1,
    RIX_CMD  = 2'd2,
    RIX_STAT = 2'd3
  } reg_idx_e;

  // command and status bit positions
  localparam int unsigned CMD_START_BIT = 0;
  localparam int unsigned CMD_CLEAR_BIT = 1;
  localparam int unsigned STAT_REQ_BIT  = 0;
  localparam int unsigned STAT_DONE_BIT = 1;

  // positions inside the synchronised control vector
  localparam int unsigned SY_TC    = 0;
  localparam int unsigned SY_DACKN = 1;
  localparam int unsigned SY_MEMWN = 2;
  localparam int unsigned SY_MEMRN = 3;
  localparam int unsigned SY_IOWN  = 4;
  localparam int unsigned SY_IORN  = 5;
  localparam int unsigned SY_AEN   = 6;
  localparam int unsigned SY_ALE   = 7;
  localparam int unsigned SYNC_N   = 8;

  // idle level of each control line: strobes and acknowledge high
  localparam logic [SYNC_N-1:0] SYNC_IDLE = 8'b0011_1110;

endpackage

// File: rtl/isa_tgt_sync.sv
module isa_tgt_sync #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= IDLE;
      q    <= IDLE;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/isa_tgt_ram.sv
module isa_tgt_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned IW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/isa_bus_target.sv
module isa_bus_target
  import isa_tgt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 20,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_BASE = 'h00300,
  parameter bit                MEM_EN    = 1'b1,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 'hD0000,
  parameter int unsigned       MEM_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ale,
  input  logic              bus_aen,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  input  logic              mem_rd_n,
  input  logic              mem_wr_n,
  input  logic [DATA_W-1:0] dat_in,
  output logic [DATA_W-1:0] dat_out,
  output logic              dat_oe,
  output logic              dma_req,
  input  logic              dma_ack_n,
  input  logic              dma_tc
);

  localparam int unsigned MIW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  // synchronised control lines
  logic [SYNC_N-1:0] raw_ctl, cur;
  assign raw_ctl = {bus_ale, bus_aen, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, dma_ack_n, dma_tc};

  isa_tgt_sync #(.N(SYNC_N), .IDLE(SYNC_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_ctl),
    .q   (cur)
  );

  // one more stage on the three strobes that commit or complete
  logic [2:0] strb_prev;  // {io_rd_n, io_wr_n, mem_wr_n}
  always_ff @(posedge clk) begin
    if (rst) strb_prev <= 3'b111;
    else     strb_prev <= {cur[SY_IORN], cur[SY_IOWN], cur[SY_MEMWN]};
  end

  logic ale_s, aen_s, dack_s, tc_s, ior_lo, memr_lo, wr_lo;
  logic ior_rise, iow_rise, memw_rise;
  assign ale_s     = cur[SY_ALE];
  assign aen_s     = cur[SY_AEN];
  assign dack_s    = ~cur[SY_DACKN];
  assign tc_s      = cur[SY_TC];
  assign ior_lo    = ~cur[SY_IORN];
  assign memr_lo   = ~cur[SY_MEMRN];
  assign wr_lo     = ~cur[SY_IOWN] | ~cur[SY_MEMWN];
  assign ior_rise  = cur[SY_IORN]  & ~strb_prev[2];
  assign iow_rise  = cur[SY_IOWN]  & ~strb_prev[1];
  assign memw_rise = cur[SY_MEMWN] & ~strb_prev[0];

  // address holding register
  logic [ADDR_W-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (ale_s) addr_q <= bus_addr;
  end

  // decode
  logic [ADDR_W-1:0] port_off, mem_off;
  logic              port_hit, mem_hit;
  reg_idx_e          idx;
  assign port_off = addr_q - PORT_BASE;
  assign mem_off  = addr_q - MEM_BASE;
  assign port_hit = ~aen_s && (port_off < ADDR_W'(PORT_REGS));
  assign mem_hit  = MEM_EN && (mem_off < ADDR_W'(MEM_DEPTH));
  assign idx      = reg_idx_e'(port_off[1:0]);

  // memory window
  logic [DATA_W-1:0] ram_q;
  generate
    if (MEM_EN) begin : g_mem
      isa_tgt_ram #(.DEPTH(MEM_DEPTH), .DW(DATA_W), .IW(MIW)) u_ram (
        .clk   (clk),
        .we    (memw_rise & mem_hit),
        .waddr (mem_off[MIW-1:0]),
        .wdata (dat_in),
        .raddr (mem_off[MIW-1:0]),
        .rdata (ram_q)
      );
    end else begin : g_nomem
      assign ram_q = '0;
    end
  endgenerate

  // register bank and DMA state
  logic [DATA_W-1:0] data_q, aux_q;
  logic              req_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      aux_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (iow_rise && port_hit) begin
        unique case (idx)
          RIX_DATA: data_q <= dat_in;
          RIX_AUX:  aux_q  <= dat_in;
          RIX_CMD: begin
            if (dat_in[CMD_START_BIT]) begin
              req_q  <= 1'b1;
              done_q <= 1'b0;
            end
            if (dat_in[CMD_CLEAR_BIT]) done_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (ior_rise && dack_s) data_q <= data_q + DATA_W'(1);
      if (tc_s && dack_s) begin
        req_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // read path
  logic              rd_sel;
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_sel = 1'b0;
    rd_val = '0;
    if (!wr_lo) begin
      if (ior_lo && dack_s) begin
        rd_sel = 1'b1;
        rd_val = data_q;
      end else if (ior_lo && port_hit) begin
        rd_sel = 1'b1;
        unique case (idx)
          RIX_DATA: rd_val = data_q;
          RIX_AUX:  rd_val = aux_q;
          RIX_CMD:  rd_val = '0;
          default: begin
            rd_val[STAT_REQ_BIT]  = req_q;
            rd_val[STAT_DONE_BIT] = done_q;
          end
        endcase
      end else if (memr_lo && mem_hit) begin
        rd_sel = 1'b1;
        rd_val = ram_q;
      end
    end
  end

  logic              oe_q;
  logic [DATA_W-1:0] out_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      out_q <= '0;
    end else begin
      oe_q  <= rd_sel;
      out_q <= rd_sel ? rd_val : '0;
    end
  end

  assign dat_oe  = oe_q;
  assign dat_out = out_q;
  assign dma_req = req_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ale_s |=> $stable(addr_q));

  // R4
  aen_block_chk: assert property (@(posedge clk) disable iff (rst)
    (aen_s && !dack_s && !(memr_lo && mem_hit)) |=> !dat_oe);

  // R6
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> !dat_oe);

  // R8
  dack_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dack_s && ior_lo && !wr_lo) |=> (dat_oe && dat_out == $past(data_q)));

  // R9
  tc_end_chk: assert property (@(posedge clk) disable iff (rst)
    (tc_s && dack_s) |=> (!dma_req && done_q));

endmodule

// File: tb/isa_bus_target_bench.sv
module isa_bus_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PBASE = 'h00300;
  localparam int MBASE = 'hD0000;
  localparam logic [7:0] IDLE_V = 8'b0011_1110;

  logic clk = 1'b0;
  logic rst;
  logic [19:0] bus_addr;
  logic bus_ale, bus_aen, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n;
  logic [7:0] dat_in;
  wire  [7:0] dat_out;
  wire  dat_oe, dma_req;
  logic dma_ack_n, dma_tc;

  int checks = 0;
  int fails  = 0;
  bit run    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_bus_target u_isa_bus_target (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_aen(bus_aen),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe), .dma_req(dma_req),
    .dma_ack_n(dma_ack_n), .dma_tc(dma_tc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model: pin history, registers, memory
  logic [7:0] pv;
  assign pv = {bus_ale, bus_aen, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, dma_ack_n, dma_tc};
  logic [7:0] h1, h2, h3;
  int m_addr;
  logic [7:0] m_data, m_aux, m_out;
  bit m_req, m_done, m_oe;
  logic [7:0] m_ram [16];

  always @(posedge clk) begin
    if (rst) begin
      h1 = IDLE_V; h2 = IDLE_V; h3 = IDLE_V;
      m_addr = 0; m_data = 0; m_aux = 0; m_req = 0; m_done = 0; m_oe = 0; m_out = 0;
    end else begin
      logic [7:0] s, p, v;
      int poff, moff;
      bit phit, mhit, dk, drv;
      s = h2; p = h3;
      poff = m_addr - PBASE;
      phit = !s[6] && poff >= 0 && poff < 4;
      moff = m_addr - MBASE;
      mhit = moff >= 0 && moff < 16;
      dk = !s[1];
      drv = 0; v = 8'h00;
      if (s[4] && s[2]) begin
        if (!s[5] && dk) begin drv = 1; v = m_data; end
        else if (!s[5] && phit) begin
          drv = 1;
          case (poff)
            0: v = m_data;
            1: v = m_aux;
            2: v = 8'h00;
            default: v = {6'b0, m_done, m_req};
          endcase
        end else if (!s[3] && mhit) begin drv = 1; v = m_ram[moff]; end
      end
      m_oe = drv; m_out = v;
      if (s[4] && !p[4] && phit) begin
        case (poff)
          0: m_data = dat_in;
          1: m_aux = dat_in;
          2: begin
            if (dat_in[0]) begin m_req = 1; m_done = 0; end
            if (dat_in[1]) m_done = 0;
          end
          default: ;
        endcase
      end
      if (s[2] && !p[2] && mhit) m_ram[moff] = dat_in;
      if (s[5] && !p[5] && dk) m_data = m_data + 8'd1;
      if (s[0] && dk) begin m_req = 0; m_done = 1; end
      if (s[7]) m_addr = int'(bus_addr);
      h3 = h2; h2 = h1; h1 = pv;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (run && !rst) begin
      chk(dat_oe === m_oe, "R5 cycle dat_oe", 32'(dat_oe), 32'(m_oe));
      chk(dat_out === m_out, "R3 cycle dat_out", 32'(dat_out), 32'(m_out));
      chk(dma_req === m_req, "R9 cycle dma_req", 32'(dma_req), 32'(m_req));
    end
  end

  // kind: 0 port read, 1 port write, 2 memory read, 3 memory write
  task automatic bus_op(input logic [19:0] a, input int kind, input logic [7:0] wd,
                        output logic [7:0] rd, output logic oe);
    @(negedge clk); bus_addr = a; bus_ale = 1'b1;
    repeat (3) @(negedge clk); bus_ale = 1'b0;
    repeat (3) @(negedge clk); bus_addr = ~a; dat_in = wd;
    case (kind)
      0: io_rd_n = 1'b0;
      1: io_wr_n = 1'b0;
      2: mem_rd_n = 1'b0;
      default: mem_wr_n = 1'b0;
    endcase
    repeat (5) @(negedge clk); rd = dat_out; oe = dat_oe;
    io_rd_n = 1'b1; io_wr_n = 1'b1; mem_rd_n = 1'b1; mem_wr_n = 1'b1;
    repeat (5) @(negedge clk); dat_in = 8'h00;
  endtask

  task automatic wr(input logic [19:0] a, input bit mem, input logic [7:0] d, input string tag);
    logic [7:0] r; logic oe;
    bus_op(a, mem ? 3 : 1, d, r, oe);
    chk(oe == 1'b0, tag, 32'(oe), 0);
  endtask

  task automatic rd_exp(input logic [19:0] a, input bit mem, input logic [7:0] e, input string tag);
    logic [7:0] r; logic oe;
    bus_op(a, mem ? 2 : 0, 8'h00, r, oe);
    chk(oe == 1'b1, tag, 32'(oe), 1);
    chk(r == e, tag, 32'(r), 32'(e));
  endtask

  task automatic rd_none(input logic [19:0] a, input bit mem, input string tag);
    logic [7:0] r; logic oe;
    bus_op(a, mem ? 2 : 0, 8'h00, r, oe);
    chk(oe == 1'b0, tag, 32'(oe), 0);
  endtask

  task automatic dma_op(input bit last, input logic [7:0] e, input string tag);
    @(negedge clk); bus_aen = 1'b1; dma_ack_n = 1'b0; dma_tc = last;
    repeat (3) @(negedge clk); io_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(dat_oe == 1'b1 && dat_out == e, tag, 32'(dat_out), 32'(e));
    io_rd_n = 1'b1;
    repeat (4) @(negedge clk); dma_tc = 1'b0; dma_ack_n = 1'b1; bus_aen = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_ale = 1'b0; bus_aen = 1'b0;
    io_rd_n = 1'b1; io_wr_n = 1'b1; mem_rd_n = 1'b1; mem_wr_n = 1'b1;
    dat_in = 8'h00; dma_ack_n = 1'b1; dma_tc = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0; run = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dat_oe == 0 && dat_out == 0 && dma_req == 0, "R1 reset outputs",
        {22'b0, dat_oe, dma_req, dat_out}, 0);
    rd_exp(20'h00300, 0, 8'h00, "R1 data after reset");
    rd_exp(20'h00301, 0, 8'h00, "R1 aux after reset");
    rd_exp(20'h00303, 0, 8'h00, "R1 status after reset");

    // R3 register map, R2 held address (bus_addr is changed before every strobe),
    // R6 no drive during writes
    wr(20'h00300, 0, 8'h5A, "R6 no oe in port write");
    wr(20'h00301, 0, 8'hC3, "R6 no oe in port write");
    rd_exp(20'h00300, 0, 8'h5A, "R3 data readback");
    rd_exp(20'h00301, 0, 8'hC3, "R2 aux readback with moved address");
    rd_exp(20'h00302, 0, 8'h00, "R3 command reads zero");
    wr(20'h00303, 0, 8'hFF, "R6 no oe in status write");
    rd_exp(20'h00303, 0, 8'h00, "R3 status write ignored");
    rd_none(20'h00304, 0, "R3 above window");
    rd_none(20'h002FF, 0, "R3 below window");

    // R4 bus owned by DMA controller
    bus_aen = 1'b1;
    wr(20'h00301, 0, 8'h11, "R4 write under aen");
    rd_none(20'h00301, 0, "R4 read under aen");
    bus_aen = 1'b0;
    rd_exp(20'h00301, 0, 8'hC3, "R4 aux kept");

    // R5 exact timing of dat_oe
    @(negedge clk); bus_addr = 20'h00301; bus_ale = 1'b1;
    repeat (3) @(negedge clk); bus_ale = 1'b0;
    repeat (3) @(negedge clk); io_rd_n = 1'b0;
    @(negedge clk); chk(dat_oe == 0, "R5 oe after edge k", 32'(dat_oe), 0);
    @(negedge clk); chk(dat_oe == 0, "R5 oe after edge k+1", 32'(dat_oe), 0);
    @(negedge clk); chk(dat_oe == 1 && dat_out == 8'hC3, "R5 oe after edge k+2", 32'(dat_out), 32'hC3);
    io_rd_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(dat_oe == 1, "R5 oe held after release k+1", 32'(dat_oe), 1);
    @(negedge clk); chk(dat_oe == 0 && dat_out == 0, "R5 release after k+2", 32'(dat_oe), 0);
    repeat (3) @(negedge clk);

    // R7 memory window
    wr(20'hD0000, 1, 8'h12, "R6 no oe in memory write");
    wr(20'hD000F, 1, 8'hEF, "R6 no oe in memory write");
    wr(20'hD0010, 1, 8'h77, "R7 write outside window");
    rd_exp(20'hD0000, 1, 8'h12, "R7 low byte kept");
    rd_exp(20'hD000F, 1, 8'hEF, "R7 top byte");
    rd_none(20'hD0010, 1, "R7 read outside window");
    bus_aen = 1'b1;
    wr(20'hD0003, 1, 8'h34, "R7 write with aen");
    rd_exp(20'hD0003, 1, 8'h34, "R7 read with aen");
    bus_aen = 1'b0;

    // R8 DMA reads, R9 terminal count
    wr(20'h00302, 0, 8'h01, "R8 start command");
    chk(dma_req == 1, "R8 request raised", 32'(dma_req), 1);
    rd_exp(20'h00303, 0, 8'h01, "R8 status shows request");
    dma_op(0, 8'h5A, "R8 dma byte 0");
    dma_op(0, 8'h5B, "R8 dma byte 1 after increment");
    dma_op(1, 8'h5C, "R8 dma byte 2");
    chk(dma_req == 0, "R9 request dropped on tc", 32'(dma_req), 0);
    rd_exp(20'h00303, 0, 8'h02, "R9 done set");
    rd_exp(20'h00300, 0, 8'h5D, "R8 data after three transfers");
    wr(20'h00302, 0, 8'h02, "R9 clear command");
    rd_exp(20'h00303, 0, 8'h00, "R9 done cleared");
    wr(20'h00302, 0, 8'h01, "R9 restart");
    dma_op(1, 8'h5D, "R8 single transfer");
    rd_exp(20'h00303, 0, 8'h02, "R9 done again");
    wr(20'h00302, 0, 8'h01, "R9 start clears done");
    rd_exp(20'h00303, 0, 8'h01, "R9 status after start");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule